// File: doc/BRIEF.md
# Storage Page Key Guard

This block decides whether a memory request may proceed. It holds one 4-bit protection key and one fetch-protect flag for each 4 KiB page of storage. Every request arrives with its address, a read/write indication and the key of the task that issued it. The block compares the task key with the key of the addressed page and answers one cycle later. The answer is exactly one of three outcomes: grant, protection exception or addressing exception.

Privileged software loads the key array through a separate key-set port. A task key of 0 passes every key check. A read of a page that carries a different key is refused only when that page is marked fetch-protected. Reads of the low-storage window below address 0x1000 are always granted. Writes to that window still follow the key rule.

Top module: `stor_key_guard`

## Requirements
- R1: After reset every page key is 0, every fetch-protect flag is clear, and all three response outputs are low.
- R2: A write to an in-range page is granted when the task key equals the page key, and otherwise raises the protection exception (unless R3 applies).
- R3: A task key of 0 is granted every read and every write to any in-range page, whatever that page's key and flag are.
- R4: A read with a task key that differs from the page key raises the protection exception only when the page's fetch-protect flag is set. Otherwise it is granted.
- R5: A read of any address below 0x1000 is granted whatever the keys and flags are. A write below 0x1000 follows R2.
- R6: When a request is presented at a clock edge, exactly one of rsp_grant, rsp_prot_exc and rsp_addr_exc is high for the following cycle. With no request, all three are low.
- R7: An address whose page index (address bits above bit 11) is NUM_PAGES or more raises rsp_addr_exc, never the protection exception, even for task key 0.
- R8: A key-set write applied at one clock edge is seen only by requests sampled at later edges. A request sampled at the same edge sees the previous key and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr_en | input | 1 | Load a key and flag into one page entry |
| key_wr_page | input | PG_W | Page index to load |
| key_wr_key | input | 4 | New protection key |
| key_wr_fetch | input | 1 | New fetch-protect flag |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_task_key | input | 4 | Key of the running task |
| rsp_grant | output | 1 | Access permitted (registered) |
| rsp_prot_exc | output | 1 | Protection exception (registered) |
| rsp_addr_exc | output | 1 | Addressing exception (registered) |

## Verification
The case that is hardest to reach is a request that arrives at the same edge as a key-set write to its own page. The request must be judged on the key and flag from before that write. Random stimulus seldom pairs the two on one page with a key that makes the outcome differ. Directed steps therefore load a page key and, in that same cycle, issue a write from the task holding the new key, which must be refused. The bench then repeats the request one cycle later, when it must be granted. After the directed steps, a long random run draws task keys and page keys from a small set so that matches are frequent. Key loads and requests often fall on the same page, and addresses also reach past the last page and into the low window.

// File: rtl/stor_key_pkg.sv
package stor_key_pkg;
  typedef logic [3:0] skey_t;
  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_GRANT = 2'd1,
    V_PROT  = 2'd2,
    V_ADDR  = 2'd3
  } verdict_e;
endpackage

// File: rtl/stor_key_table.sv
module stor_key_table
  import stor_key_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int PG_W = $clog2(NUM_PAGES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wr_page,
  input  skey_t           wr_key,
  input  logic            wr_fetch,
  input  logic [PG_W-1:0] rd_page,
  output skey_t           rd_key,
  output logic            rd_fetch
);
  skey_t key_q [NUM_PAGES];
  logic  fp_q  [NUM_PAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        key_q[i] <= '0;
        fp_q[i]  <= 1'b0;
      end
    end else if (wr_en) begin
      key_q[wr_page] <= wr_key;
      fp_q[wr_page]  <= wr_fetch;
    end
  end

  assign rd_key   = key_q[rd_page];
  assign rd_fetch = fp_q[rd_page];
endmodule

// File: rtl/stor_key_judge.sv
module stor_key_judge
  import stor_key_pkg::*;
(
  input  logic     valid,
  input  logic     is_write,
  input  logic     in_range,
  input  logic     low_window,
  input  skey_t    task_key,
  input  skey_t    page_key,
  input  logic     page_fetch,
  output verdict_e verdict
);
  logic master, match;

  assign master = (task_key == '0);
  assign match  = (task_key == page_key);

  always_comb begin
    verdict = V_NONE;
    if (valid) begin
      if (!in_range)                    verdict = V_ADDR;
      else if (master || match)         verdict = V_GRANT;
      else if (is_write)                verdict = V_PROT;
      else if (low_window || !page_fetch) verdict = V_GRANT;
      else                              verdict = V_PROT;
    end
  end
endmodule

// File: rtl/stor_key_guard.sv
module stor_key_guard
  import stor_key_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int LOW_BOUND  = 4096,
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int PIDX_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr_en,
  input  logic [PG_W-1:0]   key_wr_page,
  input  logic [3:0]        key_wr_key,
  input  logic              key_wr_fetch,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [3:0]        req_task_key,
  output logic              rsp_grant,
  output logic              rsp_prot_exc,
  output logic              rsp_addr_exc
);
  localparam logic [PIDX_W-1:0] LAST_PAGE = PIDX_W'(NUM_PAGES - 1);
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(LOW_BOUND);

  logic [PIDX_W-1:0] page_idx;
  logic              in_range, low_window;
  skey_t             page_key;
  logic              page_fetch;
  verdict_e          verdict;

  assign page_idx   = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign in_range   = (page_idx <= LAST_PAGE);
  assign low_window = (req_addr < LOW_LIMIT);

  stor_key_table #(.NUM_PAGES(NUM_PAGES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (key_wr_en),
    .wr_page  (key_wr_page),
    .wr_key   (key_wr_key),
    .wr_fetch (key_wr_fetch),
    .rd_page  (page_idx[PG_W-1:0]),
    .rd_key   (page_key),
    .rd_fetch (page_fetch)
  );

  stor_key_judge u_judge (
    .valid      (req_valid),
    .is_write   (req_write),
    .in_range   (in_range),
    .low_window (low_window),
    .task_key   (req_task_key),
    .page_key   (page_key),
    .page_fetch (page_fetch),
    .verdict    (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_grant    <= 1'b0;
      rsp_prot_exc <= 1'b0;
      rsp_addr_exc <= 1'b0;
    end else begin
      rsp_grant    <= (verdict == V_GRANT);
      rsp_prot_exc <= (verdict == V_PROT);
      rsp_addr_exc <= (verdict == V_ADDR);
    end
  end

  // R6: one outcome per request, none when idle
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_grant, rsp_prot_exc, rsp_addr_exc}));
  a_r6_answer: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_grant || rsp_prot_exc || rsp_addr_exc));
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_grant || rsp_prot_exc || rsp_addr_exc));
  // R7: out-of-range pages give the addressing exception
  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_range) |=> rsp_addr_exc);
  // R3: master key always granted in range
  a_r3_master: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_range && req_task_key == 4'd0) |=> rsp_grant);
  // R5: low-window reads always granted
  a_r5_low_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && low_window) |=> rsp_grant);
endmodule

// File: tb/tb_stor_key_guard.sv
module tb_stor_key_guard;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        key_wr_en;
  logic [3:0]  key_wr_page;
  logic [3:0]  key_wr_key;
  logic        key_wr_fetch;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_write;
  logic [3:0]  req_task_key;
  logic        rsp_grant, rsp_prot_exc, rsp_addr_exc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ref_key [NP];
  bit ref_fp [NP];

  always #5 clk = ~clk;

  stor_key_guard dut (
    .clk(clk), .rst(rst),
    .key_wr_en(key_wr_en), .key_wr_page(key_wr_page),
    .key_wr_key(key_wr_key), .key_wr_fetch(key_wr_fetch),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_task_key(req_task_key),
    .rsp_grant(rsp_grant), .rsp_prot_exc(rsp_prot_exc),
    .rsp_addr_exc(rsp_addr_exc)
  );

  // expected {grant, prot, addr}
  function automatic logic [2:0] model(bit v, int addr, bit wr, int tk);
    int pg;
    pg = addr >> 12;
    if (!v) return 3'b000;
    if (pg >= NP) return 3'b001;
    if (tk == 0 || tk == ref_key[pg]) return 3'b100;
    if (wr) return 3'b010;
    if (addr < 4096 || !ref_fp[pg]) return 3'b100;
    return 3'b010;
  endfunction

  task automatic check3(string tag, logic [2:0] exp);
    logic [2:0] act;
    act = {rsp_grant, rsp_prot_exc, rsp_addr_exc};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: optional key load and request, then compare
  task automatic step(string tag, bit kw, int kp, int kk, bit kf,
                      bit v, int addr, bit wr, int tk);
    logic [2:0] exp;
    key_wr_en = kw; key_wr_page = kp[3:0]; key_wr_key = kk[3:0]; key_wr_fetch = kf;
    req_valid = v; req_addr = addr[23:0]; req_write = wr; req_task_key = tk[3:0];
    exp = model(v, addr, wr, tk);
    if (kw) begin ref_key[kp] = kk; ref_fp[kp] = kf; end
    @(posedge clk);
    @(negedge clk);
    check3(tag, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin ref_key[i] = 0; ref_fp[i] = 0; end
    rst = 1'b1;
    key_wr_en = 0; key_wr_page = 0; key_wr_key = 0; key_wr_fetch = 0;
    req_valid = 0; req_addr = 0; req_write = 0; req_task_key = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check3("R1 reset outputs", 3'b000);
    step("R1 flags clear: read granted", 0,0,0,0, 1, 32'h3010, 0, 5);
    step("R1 keys zero: write refused", 0,0,0,0, 1, 32'h3010, 1, 5);
    // R8: same-edge load is not yet visible
    step("R8 same-cycle old key", 1,3,5,0, 1, 32'h3020, 1, 5);
    step("R8 next-cycle new key", 0,0,0,0, 1, 32'h3020, 1, 5);
    step("R2 mismatched write", 0,0,0,0, 1, 32'h3020, 1, 6);
    step("R3 key0 write", 0,0,0,0, 1, 32'h3020, 1, 0);
    step("R4 read unprotected", 0,0,0,0, 1, 32'h3020, 0, 6);
    step("R8 flag same cycle", 1,3,5,1, 1, 32'h3020, 0, 6);
    step("R4 read fetch-protected", 0,0,0,0, 1, 32'h3020, 0, 6);
    step("R4 matching read", 0,0,0,0, 1, 32'h3020, 0, 5);
    step("R3 key0 read protected", 0,0,0,0, 1, 32'h3020, 0, 0);
    step("R5 load page0", 1,0,7,1, 0, 0, 0, 0);
    step("R5 low read granted", 0,0,0,0, 1, 32'h0800, 0, 2);
    step("R5 low write refused", 0,0,0,0, 1, 32'h0800, 1, 2);
    step("R2 low write matching", 0,0,0,0, 1, 32'h0FFC, 1, 7);
    step("R7 beyond last page", 0,0,0,0, 1, 32'h10000, 0, 0);
    step("R7 beyond last write", 0,0,0,0, 1, 32'h13FF0, 1, 4);
    step("R6 idle", 0,0,0,0, 0, 32'h3020, 0, 6);
    for (int n = 0; n < 3000; n++) begin
      step("R6 random", ($urandom_range(0,3) == 0), $urandom_range(0,15),
           $urandom_range(0,3), $urandom_range(0,1),
           ($urandom_range(0,4) != 0),
           ($urandom_range(0,19) << 12) | $urandom_range(0,4095),
           $urandom_range(0,1), $urandom_range(0,3));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule